// File: doc/BRIEF.md
# Harvester Calibration Measurement Sequencer

This block runs the periodic calibration of a capacitive vibration energy harvester. In normal operation it counts time-base ticks until the calibration interval has passed. It then powers up the successive approximation converter and holds the pump threshold at zero, so the store node settles to the reservoir voltage. During a settling window it keeps the first converter code as the reservoir measurement.

When the window closes, the block releases charge pumping and watches every converter code on the store node. Two equal codes in a row mean the store voltage has saturated, and that code is taken as the maximum. If the store voltage never plateaus, the block stops after a set number of samples, keeps the last code and raises an error flag. A one-cycle pulse then tells the threshold logic that both codes are ready. In the same cycle the converter is switched off. After that the maximum register returns to zero and the reservoir code stays until the next calibration.

All durations are counted in time-base ticks, and the converter is used only inside the calibration cycle.

Top module: `harv_cal_seq`

## Requirements
- R1: After reset every control output is low. The reservoir code, the maximum code and the error flag read zero.
- R2: In normal operation, the tick that completes INTERVAL_TICKS ticks raises `thr_zero` on the next clock edge. On that same edge `adc_on` goes high for exactly one cycle. Counting starts again from zero each time normal operation resumes.
- R3: `thr_zero` stays high for exactly SETTLE_TICKS ticks. On the edge that ends the window, `thr_zero` falls and `pump_start` rises together. Only one of `thr_zero`, `pump_start` and `codes_valid` is ever high at a time.
- R4: The first valid code inside the settling window is loaded into `res_code`. It is loaded only once per calibration. Later codes in the window, codes during pumping and codes in normal operation leave it unchanged.
- R5: During pumping, a valid code equal to the previous valid code of the same pumping phase ends the measurement. That code becomes `max_code`, visible in the cycle `codes_valid` is high. The first code of a phase never ends it.
- R6: If the MAX_SAMPLES-th pumping code does not equal its predecessor, the measurement still ends. That code becomes `max_code` and `no_plateau` is set. A plateau found on that same sample counts as a plateau, with no error. `no_plateau` holds until the next calibration starts, and is cleared on that edge.
- R7: When a measurement ends, `codes_valid` and `adc_off` are high for one cycle, with `pump_start` low. In the following cycle `max_code` reads zero, while `res_code` keeps its value.
- R8: Converter strobes in normal operation change no output and do not advance the interval count.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time-base tick, one cycle per time unit |
| adc_valid | input | 1 | Converter code strobe |
| adc_code | input | CODE_W | Converter output code |
| adc_on | output | 1 | One-cycle converter power-up request |
| adc_off | output | 1 | One-cycle converter power-down request |
| thr_zero | output | 1 | Forces the lower pump threshold to zero |
| pump_start | output | 1 | Charge pumping released, store sampling active |
| codes_valid | output | 1 | One-cycle pulse: reservoir and maximum codes ready |
| res_code | output | CODE_W | Registered reservoir code |
| max_code | output | CODE_W | Registered maximum store code, zero outside the report cycle |
| no_plateau | output | 1 | Last measurement ended on the sample limit |

## Verification
The assertions watch, on every cycle, the properties that hold from one cycle to the next:
- the three phase outputs never overlap, and the tick counters stay below their limits;
- pumping follows directly on the end of the settling window;
- the maximum register takes the code of its final sample and is cleared right after the report;
- the reservoir code never moves outside the settling window;
- the error flag only rises together with the report pulse.

Only the bench scenarios can show the exact tick counts of the interval and window, and that only the first settling code is captured. They also show which sample ends a measurement: a plateau, the sample limit, and the tie when both fall on the last sample. Finally, they show that strobes in normal operation are ignored.

// File: rtl/harv_cal_pkg.sv
package harv_cal_pkg;

  typedef enum logic [1:0] {
    PH_NORMAL = 2'd0,
    PH_SETTLE = 2'd1,
    PH_PUMP   = 2'd2,
    PH_REPORT = 2'd3
  } cal_phase_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/harv_tick_timer.sv
module harv_tick_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expire = en && tick && (cnt_q == limit - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && tick) begin
      cnt_d = expire ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2 / R3: the running count never reaches the active limit
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < limit));

endmodule

// File: rtl/harv_plateau_det.sv
module harv_plateau_det #(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned MAX_SAMPLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  output logic              done,
  output logic              timeout
);

  localparam int unsigned SW = $clog2(MAX_SAMPLES + 1);

  logic [CODE_W-1:0] prev_q, prev_d;
  logic              have_q, have_d;
  logic [SW-1:0]     nsamp_q, nsamp_d;
  logic              same;
  logic              last;

  assign same    = have_q && (code == prev_q);
  assign last    = (nsamp_q == SW'(MAX_SAMPLES - 1));
  assign done    = en && valid && (same || last);
  assign timeout = done && !same;

  always_comb begin
    prev_d  = prev_q;
    have_d  = have_q;
    nsamp_d = nsamp_q;
    if (!en) begin
      have_d  = 1'b0;
      nsamp_d = '0;
    end else if (valid) begin
      prev_d = code;
      have_d = 1'b1;
      if (!last) begin
        nsamp_d = nsamp_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      have_q  <= 1'b0;
      nsamp_q <= '0;
    end else begin
      prev_q  <= prev_d;
      have_q  <= have_d;
      nsamp_q <= nsamp_d;
    end
  end

  // R6: sample count is capped by the limit
  p_sample_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nsamp_q <= SW'(MAX_SAMPLES - 1));

endmodule

// File: rtl/harv_cal_seq.sv
module harv_cal_seq
  import harv_cal_pkg::*;
#(
  parameter int unsigned CODE_W         = 8,
  parameter int unsigned INTERVAL_TICKS = 9000,
  parameter int unsigned SETTLE_TICKS   = 200,
  parameter int unsigned MAX_SAMPLES    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_code,
  output logic              adc_on,
  output logic              adc_off,
  output logic              thr_zero,
  output logic              pump_start,
  output logic              codes_valid,
  output logic [CODE_W-1:0] res_code,
  output logic [CODE_W-1:0] max_code,
  output logic              no_plateau
);

  localparam int unsigned LIM_MAX = max_of(INTERVAL_TICKS, SETTLE_TICKS);
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s = rs_q[1];

  cal_phase_t        phase_q, phase_d;
  logic              tmr_en, tmr_clr, tmr_expire;
  logic [CNT_W-1:0]  tmr_limit;
  logic              pl_en, pl_done, pl_timeout;
  logic              cal_begin;

  logic [CODE_W-1:0] res_q, res_d;
  logic              taken_q, taken_d;
  logic [CODE_W-1:0] max_q, max_d;
  logic              err_q, err_d;
  logic              on_q, on_d;
  logic              res_ld;

  // phase sequencing
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_NORMAL: if (tmr_expire) phase_d = PH_SETTLE;
      PH_SETTLE: if (tmr_expire) phase_d = PH_PUMP;
      PH_PUMP:   if (pl_done)    phase_d = PH_REPORT;
      PH_REPORT: phase_d = PH_NORMAL;
      default:   phase_d = PH_NORMAL;
    endcase
  end

  assign tmr_en    = (phase_q == PH_NORMAL) || (phase_q == PH_SETTLE);
  assign tmr_clr   = (phase_d != phase_q);
  assign tmr_limit = (phase_q == PH_SETTLE) ? CNT_W'(SETTLE_TICKS) : CNT_W'(INTERVAL_TICKS);
  assign pl_en     = (phase_q == PH_PUMP);
  assign cal_begin = (phase_q == PH_NORMAL) && (phase_d == PH_SETTLE);

  harv_tick_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr    (tmr_clr),
    .en     (tmr_en),
    .tick   (tick),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  harv_plateau_det #(
    .CODE_W      (CODE_W),
    .MAX_SAMPLES (MAX_SAMPLES)
  ) u_plateau (
    .clk     (clk),
    .rst_n   (rst_s),
    .en      (pl_en),
    .valid   (adc_valid),
    .code    (adc_code),
    .done    (pl_done),
    .timeout (pl_timeout)
  );

  // result registers: next-state logic
  assign res_ld = (phase_q == PH_SETTLE) && adc_valid && !taken_q;

  always_comb begin
    res_d   = res_q;
    taken_d = taken_q;
    max_d   = max_q;
    err_d   = err_q;
    on_d    = cal_begin;
    if (res_ld) begin
      res_d   = adc_code;
      taken_d = 1'b1;
    end else if (phase_q == PH_NORMAL) begin
      taken_d = 1'b0;
    end
    if (pl_done) begin
      max_d = adc_code;
    end else if (phase_q == PH_REPORT) begin
      max_d = '0;
    end
    if (cal_begin) begin
      err_d = 1'b0;
    end else if (pl_done) begin
      err_d = pl_timeout;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      phase_q <= PH_NORMAL;
      res_q   <= '0;
      taken_q <= 1'b0;
      max_q   <= '0;
      err_q   <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      res_q   <= res_d;
      taken_q <= taken_d;
      max_q   <= max_d;
      err_q   <= err_d;
      on_q    <= on_d;
    end
  end

  assign adc_on      = on_q;
  assign adc_off     = (phase_q == PH_REPORT);
  assign thr_zero    = (phase_q == PH_SETTLE);
  assign pump_start  = (phase_q == PH_PUMP);
  assign codes_valid = (phase_q == PH_REPORT);
  assign res_code    = res_q;
  assign max_code    = max_q;
  assign no_plateau  = err_q;

  // R3: phase outputs never overlap
  p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({thr_zero, pump_start, codes_valid}));

  // R3: pumping follows the settling window directly
  p_pump_after_settle_r3: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(thr_zero) |-> pump_start);

  // R2: power-up coincides with the start of the window
  p_on_in_settle_r2: assert property (@(posedge clk) disable iff (!rst_s)
    adc_on |-> (thr_zero && !$past(thr_zero)));

  // R4: reservoir code moves only from inside the settling window
  p_res_hold_r4: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(thr_zero) |-> $stable(res_code));

  // R5: the maximum takes the final sample code
  p_max_from_code_r5: assert property (@(posedge clk) disable iff (!rst_s)
    pl_done |=> (max_code == $past(adc_code)));

  // R7: maximum cleared right after the report pulse
  p_max_clear_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $past(codes_valid) |-> (max_code == '0));

  // R6: the error flag only rises with the report
  p_err_at_report_r6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(no_plateau) |-> codes_valid);

endmodule

// File: tb/harv_cal_seq_bench.sv
module harv_cal_seq_bench;

  localparam int unsigned CW  = 8;
  localparam int unsigned INT = 8;
  localparam int unsigned SET = 4;
  localparam int unsigned MS  = 5;

  logic          clk;
  logic          rst_n;
  logic          tick;
  logic          adc_valid;
  logic [CW-1:0] adc_code;
  logic          adc_on, adc_off, thr_zero, pump_start, codes_valid, no_plateau;
  logic [CW-1:0] res_code, max_code;

  int total;
  int bad;
  bit finished;

  harv_cal_seq #(
    .CODE_W         (CW),
    .INTERVAL_TICKS (INT),
    .SETTLE_TICKS   (SET),
    .MAX_SAMPLES    (MS)
  ) u_harv_cal_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .adc_valid   (adc_valid),
    .adc_code    (adc_code),
    .adc_on      (adc_on),
    .adc_off     (adc_off),
    .thr_zero    (thr_zero),
    .pump_start  (pump_start),
    .codes_valid (codes_valid),
    .res_code    (res_code),
    .max_code    (max_code),
    .no_plateau  (no_plateau)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic send_code(input int c);
    adc_code  = CW'(c);
    adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "adc_on", int'(adc_on), 0);
    chk("R1", "adc_off", int'(adc_off), 0);
    chk("R1", "thr_zero", int'(thr_zero), 0);
    chk("R1", "pump_start", int'(pump_start), 0);
    chk("R1", "codes_valid", int'(codes_valid), 0);
    chk("R1", "res_code", int'(res_code), 0);
    chk("R1", "max_code", int'(max_code), 0);
    chk("R1", "no_plateau", int'(no_plateau), 0);
  endtask

  task automatic t_idle_ignore;
    give_ticks(3);
    send_code(55);
    chk("R8", "res_code", int'(res_code), 0);
    chk("R8", "max_code", int'(max_code), 0);
    chk("R8", "codes_valid", int'(codes_valid), 0);
    chk("R8", "adc_on", int'(adc_on), 0);
    give_ticks(4);
    chk("R8", "thr_zero after 7 ticks", int'(thr_zero), 0);
    give_ticks(1);
    chk("R8", "thr_zero after 8 ticks", int'(thr_zero), 1);
  endtask

  task automatic t_cal_plateau;
    chk("R2", "adc_on at start", int'(adc_on), 1);
    step(1);
    chk("R2", "adc_on one cycle", int'(adc_on), 0);
    send_code(77);
    send_code(99);
    chk("R4", "res first code", int'(res_code), 77);
    give_ticks(SET - 1);
    chk("R3", "thr_zero held", int'(thr_zero), 1);
    chk("R3", "pump_start early", int'(pump_start), 0);
    give_ticks(1);
    chk("R3", "thr_zero end", int'(thr_zero), 0);
    chk("R3", "pump_start", int'(pump_start), 1);
    send_code(20);
    chk("R5", "first code no end", int'(codes_valid), 0);
    send_code(10);
    send_code(20);
    chk("R5", "no end on non-adjacent", int'(codes_valid), 0);
    send_code(20);
    chk("R5", "codes_valid", int'(codes_valid), 1);
    chk("R5", "max_code", int'(max_code), 20);
    chk("R6", "no error", int'(no_plateau), 0);
    chk("R7", "adc_off", int'(adc_off), 1);
    chk("R7", "pump_start low", int'(pump_start), 0);
    chk("R4", "res during pump", int'(res_code), 77);
    step(1);
    chk("R7", "codes_valid one cycle", int'(codes_valid), 0);
    chk("R7", "adc_off one cycle", int'(adc_off), 0);
    chk("R7", "max cleared", int'(max_code), 0);
    chk("R7", "res kept", int'(res_code), 77);
  endtask

  task automatic t_cal_timeout;
    give_ticks(INT - 1);
    chk("R2", "interval restart", int'(thr_zero), 0);
    give_ticks(1);
    chk("R2", "second start", int'(thr_zero), 1);
    send_code(33);
    give_ticks(SET);
    chk("R4", "res new cycle", int'(res_code), 33);
    for (int i = 1; i < int'(MS); i++) send_code(i);
    chk("R6", "not yet ended", int'(codes_valid), 0);
    send_code(200);
    chk("R6", "ended on limit", int'(codes_valid), 1);
    chk("R6", "max last code", int'(max_code), 200);
    chk("R6", "error set", int'(no_plateau), 1);
    step(1);
    chk("R6", "error held", int'(no_plateau), 1);
  endtask

  task automatic t_cal_tie;
    give_ticks(INT);
    chk("R6", "error cleared at start", int'(no_plateau), 0);
    give_ticks(SET);
    chk("R4", "res kept without code", int'(res_code), 33);
    for (int i = 1; i < int'(MS); i++) send_code(i);
    send_code(MS - 1);
    chk("R6", "tie ends", int'(codes_valid), 1);
    chk("R6", "tie max", int'(max_code), int'(MS) - 1);
    chk("R6", "tie no error", int'(no_plateau), 0);
    step(1);
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    tick = 1'b0;
    adc_valid = 1'b0;
    adc_code = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_idle_ignore();
    t_cal_plateau();
    t_cal_timeout();
    t_cal_tie();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule